// File: doc/BRIEF.md
# Pad Receive Conditioning Path

This block sits between the receive buffer of a single pad and the logic that consumes its level. It takes the pad's raw receive value, applies an optional force-to-one override, brings the value into the block clock domain through a two-flop synchronizer, and optionally passes it through a glitch filter. The filter accepts a new level only after that level has held for a parameterized number of clocks. The selected level then goes through an optional polarity inversion.

The conditioned result drives the event output that interrupt and wake logic consume. Active-low pins are handled by setting the inversion bit. The native-function output carries one of two values, picked by a select bit: the raw pad pin with no processing, or the same conditioned level that the event output carries. A readback bit exposes the selected level before inversion. It reads 0 whenever the receive buffer is disabled.

Top module: `pad_rx_cond`

## Requirements
- R1: With the filter select at 0, a change on `pad_rx` (buffer enabled, no override) reaches `event_rx` two clock edges after it is applied, and no earlier.
- R2: With the filter select at 1, a new level on `pad_rx` reaches `event_rx` and `rx_readback` FILT_CYCLES+2 edges after it is applied, provided it holds. One edge earlier, the old level is still shown.
- R3: With the filter select at 1, a pulse on `pad_rx` that lasts fewer than FILT_CYCLES clocks never reaches `event_rx`.
- R4: `inv_en` = 1 inverts `event_rx` at once. `rx_readback` is not affected by `inv_en`.
- R5: With `nat_sync_sel` = 0, `native_rx` equals `pad_rx` in the same cycle, without synchronization, override or inversion.
- R6: With `nat_sync_sel` = 1, `native_rx` equals `event_rx`.
- R7: `force_one` = 1 makes the path behave as if the pad were at 1, with the same two-edge latency. The override is applied before inversion and does not alter `native_rx` when `nat_sync_sel` = 0.
- R8: While `rx_buf_dis` = 1, `rx_readback` reads 0 at once. The internal state goes to 0 two edges later, whatever `pad_rx` and `force_one` are.
- R9: During reset, the synchronizer and the filter hold 0, so `event_rx` equals `inv_en` and `rx_readback` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_rx | input | 1 | Raw receive value from the pad buffer |
| rx_buf_dis | input | 1 | 1 = receive buffer disabled, internal state driven to 0 |
| force_one | input | 1 | 1 = override the received value to 1 |
| filt_sel | input | 1 | 0 = synchronized unfiltered state, 1 = synchronized filtered state |
| inv_en | input | 1 | 1 = invert the selected state |
| nat_sync_sel | input | 1 | 0 = native function gets raw pad, 1 = gets conditioned state |
| native_rx | output | 1 | Receive value delivered to the native function |
| event_rx | output | 1 | Conditioned state for event and interrupt logic |
| rx_readback | output | 1 | Readable receive state: selected level, never inverted |

## Verification
Each result has its own latency. The raw native path and the readback gating respond in the same cycle as the stimulus. The unfiltered event responds two edges later. The filtered event responds FILT_CYCLES+2 edges later. The driver attaches an exact due cycle to every expected value it queues, and it also queues the old value one cycle before each change is due. As a result, an output that responds early fails just as an output that responds late does. The monitor compares each queued item only in its due cycle, at a point that lies between the input drive point and the next rising edge.

// File: rtl/pad_rx_cond.sv
module pad_rx_cond #(
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_rx,
  input  logic rx_buf_dis,
  input  logic force_one,
  input  logic filt_sel,
  input  logic inv_en,
  input  logic nat_sync_sel,
  output logic native_rx,
  output logic event_rx,
  output logic rx_readback
);

  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] CLAST = CW'(FILT_CYCLES - 1);

  logic          buf_val;
  logic          s1, s2;
  logic          filt_q;
  logic [CW-1:0] cnt;
  logic          sel_st;

  assign buf_val = !rx_buf_dis && (force_one || pad_rx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= buf_val;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt    <= '0;
    end else if (s2 == filt_q) begin
      cnt <= '0;
    end else if (cnt == CLAST) begin
      filt_q <= s2;
      cnt    <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sel_st      = filt_sel ? filt_q : s2;
  assign event_rx    = sel_st ^ inv_en;
  assign native_rx   = nat_sync_sel ? event_rx : pad_rx;
  assign rx_readback = sel_st && !rx_buf_dis;

endmodule

// File: rtl/pad_rx_cond_chk.sv
module pad_rx_cond_chk #(
  parameter int FILT_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic rx_buf_dis,
  input logic force_one,
  input logic filt_sel,
  input logic inv_en,
  input logic event_rx,
  input logic rx_readback,
  input logic s2,
  input logic filt_q
);

  localparam int SW = $clog2(FILT_CYCLES + 2) + 1;
  localparam logic [SW-1:0] SMAX = SW'(FILT_CYCLES);

  logic [SW-1:0] streak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             streak <= '0;
    else if (s2 == filt_q)  streak <= '0;
    else if (streak < SMAX) streak <= streak + 1'b1;
  end

  p_disabled_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_buf_dis && $past(rx_buf_dis) && $past(rx_buf_dis, 2) && !filt_sel)
      |-> (event_rx == inv_en));

  p_force_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_one && $past(force_one) && $past(force_one, 2) &&
     !rx_buf_dis && !$past(rx_buf_dis) && !$past(rx_buf_dis, 2) && !filt_sel)
      |-> (event_rx == !inv_en));

  p_rdbk_noinv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_buf_dis |-> (rx_readback == (event_rx ^ inv_en)));

  p_filt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (streak >= SMAX));

endmodule

bind pad_rx_cond pad_rx_cond_chk #(.FILT_CYCLES(FILT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_buf_dis(rx_buf_dis), .force_one(force_one),
  .filt_sel(filt_sel), .inv_en(inv_en), .event_rx(event_rx),
  .rx_readback(rx_readback), .s2(s2), .filt_q(filt_q)
);

// File: tb/pad_rx_cond_test.sv
module pad_rx_cond_test;
  localparam int N = 4;
  localparam int EVT = 0, NAT = 1, RDB = 2;

  typedef struct {
    int    due;
    int    sig;
    bit    val;
    string req;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic pad_rx = 0, rx_buf_dis = 0, force_one = 0, filt_sel = 0, inv_en = 0, nat_sync_sel = 0;
  logic native_rx, event_rx, rx_readback;
  int cyc = 0, total = 0, bad = 0;
  bit done = 0;
  exp_t exp_q[$];

  pad_rx_cond #(.FILT_CYCLES(N)) uut (
    .clk(clk), .rst_n(rst_n), .pad_rx(pad_rx), .rx_buf_dis(rx_buf_dis),
    .force_one(force_one), .filt_sel(filt_sel), .inv_en(inv_en),
    .nat_sync_sel(nat_sync_sel), .native_rx(native_rx), .event_rx(event_rx),
    .rx_readback(rx_readback)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit act, input bit expv, input string req, input string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s cyc=%0d actual=%0b expected=%0b", req, what, cyc, act, expv);
    end
  endtask

  task automatic expect_at(input int dly, input int sig, input bit val, input string req);
    exp_t e;
    e.due = cyc + dly; e.sig = sig; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    exp_t keep[$];
    #1;
    keep = {};
    foreach (exp_q[i]) begin
      if (exp_q[i].due == cyc) begin
        case (exp_q[i].sig)
          EVT:     chk(event_rx, exp_q[i].val, exp_q[i].req, "event_rx");
          NAT:     chk(native_rx, exp_q[i].val, exp_q[i].req, "native_rx");
          default: chk(rx_readback, exp_q[i].val, exp_q[i].req, "rx_readback");
        endcase
      end else begin
        keep.push_back(exp_q[i]);
      end
    end
    exp_q = keep;
  end

  initial begin
    step(2);
    #1;
    chk(event_rx, 1'b0, "R9", "event_rx in reset");
    chk(rx_readback, 1'b0, "R9", "rx_readback in reset");
    inv_en = 1;
    #1;
    chk(event_rx, 1'b1, "R9", "event_rx in reset, inverted");
    step(1);
    inv_en = 0;
    rst_n = 1;
    step(2);

    // R1 and R6: unfiltered latency, native follows the event
    nat_sync_sel = 1;
    pad_rx = 1;
    expect_at(0, NAT, 0, "R6");
    expect_at(1, EVT, 0, "R1");
    expect_at(2, EVT, 1, "R1");
    expect_at(2, NAT, 1, "R6");
    step(4);

    // R5: raw native path
    nat_sync_sel = 0;
    pad_rx = 0;
    expect_at(0, NAT, 0, "R5");
    expect_at(1, EVT, 1, "R1");
    expect_at(2, EVT, 0, "R1");
    step(3);
    pad_rx = 1;
    expect_at(0, NAT, 1, "R5");
    expect_at(0, EVT, 0, "R5");
    step(4);

    // R4: inversion on the event, not on readback
    inv_en = 1;
    expect_at(0, EVT, 0, "R4");
    expect_at(0, RDB, 1, "R4");
    step(2);
    inv_en = 0;
    pad_rx = 0;
    step(8);

    // R2: filtered latency rising
    filt_sel = 1;
    pad_rx = 1;
    expect_at(N + 1, EVT, 0, "R2");
    expect_at(N + 2, EVT, 1, "R2");
    expect_at(N + 1, RDB, 0, "R2");
    expect_at(N + 2, RDB, 1, "R2");
    step(N + 6);

    // R3: a pulse one clock shorter than the filter length is rejected
    pad_rx = 0;
    expect_at(N + 2, EVT, 1, "R3");
    expect_at(N + 3, EVT, 1, "R3");
    expect_at(N + 4, EVT, 1, "R3");
    expect_at(N + 4, RDB, 1, "R3");
    step(N - 1);
    pad_rx = 1;
    step(N + 8);

    // R2: filtered latency falling
    pad_rx = 0;
    expect_at(N + 1, EVT, 1, "R2");
    expect_at(N + 2, EVT, 0, "R2");
    step(N + 6);

    // R7: override before inversion
    filt_sel = 0;
    force_one = 1;
    expect_at(0, NAT, 0, "R7");
    expect_at(1, EVT, 0, "R7");
    expect_at(2, EVT, 1, "R7");
    step(4);
    inv_en = 1;
    expect_at(0, EVT, 0, "R7");
    expect_at(0, RDB, 1, "R7");
    step(2);
    inv_en = 0;
    force_one = 0;
    pad_rx = 1;
    step(4);

    // R8: buffer disable
    rx_buf_dis = 1;
    expect_at(0, RDB, 0, "R8");
    expect_at(1, EVT, 1, "R8");
    expect_at(2, EVT, 0, "R8");
    step(3);
    force_one = 1;
    expect_at(2, EVT, 0, "R8");
    expect_at(2, RDB, 0, "R8");
    step(4);
    rx_buf_dis = 0;
    expect_at(0, RDB, 0, "R8");
    expect_at(2, EVT, 1, "R8");
    expect_at(2, RDB, 1, "R8");
    step(4);
    force_one = 0;
    step(3);

    if (exp_q.size() != 0) begin
      bad++;
      total++;
      $display("FAIL scoreboard %0d items never checked, expected 0", exp_q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run hung actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule